// File: doc/BRIEF.md
# Bridge-Steered PWM Generator

This block produces a pulse-width-modulated waveform with 10-bit duty resolution and routes it onto four output pins, A through D, so that one generator can drive a single load, a complementary half-bridge, or an H-bridge in either direction. An 8-bit timer is extended by a 2-bit sub-count into a 10-bit phase. The phase runs from zero up to the programmed period with its low two bits all ones, and then wraps. The output is active while the phase is below the latched duty value. The duty value is assembled from an 8-bit high part and a 2-bit low part. It is captured only when the phase wraps, or while the generator is switched off.

A 2-bit bridge field selects how the waveform is steered, and a 2-bit polarity field inverts the A/C pair and the B/D pair independently. In half-bridge steering, A and B are driven in complement. A small state machine delays every turn-on by a programmed number of clock cycles, so the two switches are never on together. Pins that the selected steering does not use have their output enables low, which hands them back to general I/O. When the generator is off, all four enables are low and pin A is left to whatever capture or compare logic owns it.

The dead-band machine has five states. DB_OFF means both sides are off, and the machine is held there whenever half-bridge steering is inactive. DB_A_ON and DB_B_ON mean one side is conducting. DB_WAIT_A and DB_WAIT_B are dead-time countdowns before A or B turns on. Its transitions are:
- start: DB_OFF goes to the ON or WAIT state that matches the current waveform level.
- swap: an ON state goes to the opposite WAIT state when the waveform flips. It goes directly to the opposite ON state when the dead-band count is zero.
- expire: a WAIT state goes to its ON state when its counter reaches one.
- abort: a WAIT state goes to the opposite WAIT state, with the counter reloaded, if the waveform flips back during the wait.
- release: any state goes to DB_OFF when half-bridge steering stops.

Top module: `pwm_steer_top`

## Requirements
- R1: After reset with the generator off, all four pin levels are 0 and all four pin enables are 0.
- R2: While `pwm_on` is low, all enables and pin levels are 0, the phase counter is held at zero, and the duty inputs are loaded continuously.
- R3: With period P and duty value D = {duty_hi, duty_lo}, the waveform repeats every 4·(P+1) clock cycles. It is active for min(D, 4·(P+1)) of those cycles, and each active run starts when the phase restarts.
- R4: A change of the duty inputs during a period takes effect only when the phase wraps, never in the middle of a period.
- R5: Bridge code 00 (single) places the waveform on A, with enables 0001 (bit 0 = A, bit 3 = D).
- R6: Bridge code 10 (half-bridge) drives A with the waveform and B with its complement, with enables 0011. With a dead-band of zero, B is the exact complement of A.
- R7: In half-bridge steering with dead-band N > 0, each side turns on only after the waveform has held its new level for N+1 consecutive cycles, so A and B are both off for N cycles around each edge. A pulse shorter than N+1 cycles never turns its side on.
- R8: Bridge code 01 (forward) holds A active, holds B and C inactive, and modulates D, with enables 1111.
- R9: Bridge code 11 (reverse) holds C active, holds A and D inactive, and modulates B, with enables 1111.
- R10: Polarity bit 1 inverts the active level of A and C, and polarity bit 0 inverts the active level of B and D. Disabled pins stay at 0 whatever the polarity.
- R11: A duty value of zero keeps the waveform inactive for the whole period. A duty value at or above 4·(P+1) keeps it active for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_on | input | 1 | Generator enable; low returns the pins to other owners |
| duty_hi | input | 8 | High 8 bits of the duty value |
| duty_lo | input | 2 | Low 2 bits of the duty value, compared against the sub-count |
| period | input | 8 | Timer value at which the phase wraps |
| bridge_cfg | input | 2 | Steering: 00 single, 01 forward, 10 half-bridge, 11 reverse |
| pol_sel | input | 2 | Bit 1: A/C active-low; bit 0: B/D active-low |
| dead_cnt | input | 6 | Dead-band length in clock cycles |
| pin_lvl | output | 4 | Pin levels, bit 0 = A to bit 3 = D |
| pin_oe | output | 4 | Pin output enables, same bit order |

## Verification
The assertions assume that `period` and `dead_cnt` stay constant while the generator and half-bridge steering are running. If the period were lowered mid-run, the phase could pass its wrap point, and the duty-hold and rise-position properties would no longer describe the intended waveform. The stimulus therefore changes the period only while `pwm_on` is low. It changes the dead-band only while the bridge code is not half-bridge, and it moves duty values, bridge codes and polarity freely at arbitrary cycles. Inputs change one time unit after a rising edge, so every register sees a stable value at the next edge.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    typedef enum logic [1:0] {
        CFG_SINGLE = 2'b00,
        CFG_FWD    = 2'b01,
        CFG_HALF   = 2'b10,
        CFG_REV    = 2'b11
    } bridge_cfg_e;

    typedef enum logic [2:0] {
        DB_OFF    = 3'd0,
        DB_A_ON   = 3'd1,
        DB_WAIT_B = 3'd2,
        DB_B_ON   = 3'd3,
        DB_WAIT_A = 3'd4
    } db_state_e;

    localparam int NPINS = 4;
    localparam int PIN_A = 0;
    localparam int PIN_B = 1;
    localparam int PIN_C = 2;
    localparam int PIN_D = 3;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int TW   = 8,
    parameter int SUBW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TW-1:0]   period,
    input  logic [TW-1:0]   duty_hi,
    input  logic [SUBW-1:0] duty_lo,
    output logic            mod_now,
    output logic            mod_q
);
    localparam int CW = TW + SUBW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] duty_q;
    logic [CW-1:0] wrap_val;
    logic [CW-1:0] duty_in;
    logic          at_wrap;

    always_comb begin
        wrap_val = {period, {SUBW{1'b1}}};
        duty_in  = {duty_hi, duty_lo};
        at_wrap  = (cnt_q == wrap_val);
        mod_now  = run && (cnt_q < duty_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
            mod_q  <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            duty_q <= duty_in;
            mod_q  <= 1'b0;
        end else begin
            mod_q <= mod_now;
            if (at_wrap) begin
                cnt_q  <= '0;
                duty_q <= duty_in;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !at_wrap) |=> $stable(duty_q)); // R4

    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0) && !mod_q); // R2

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_q) |-> (cnt_q == {{(CW-1){1'b0}}, 1'b1})); // R3

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import pwm_steer_pkg::*;
#(
    parameter int DBW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic           mod_now,
    input  logic [DBW-1:0] dead,
    output logic           on_a,
    output logic           on_b
);
    db_state_e      state_q, state_d;
    logic [DBW-1:0] wait_q, wait_d;
    logic           no_gap;

    assign no_gap = (dead == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_OFF;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        if (!active) begin
            state_d = DB_OFF;
            wait_d  = '0;
        end else begin
            unique case (state_q)
                DB_OFF: begin
                    wait_d = dead;
                    if (mod_now) state_d = no_gap ? DB_A_ON : DB_WAIT_A;
                    else         state_d = no_gap ? DB_B_ON : DB_WAIT_B;
                end
                DB_A_ON: begin
                    if (!mod_now) begin
                        state_d = no_gap ? DB_B_ON : DB_WAIT_B;
                        wait_d  = dead;
                    end
                end
                DB_WAIT_B: begin
                    if (mod_now) begin
                        state_d = no_gap ? DB_A_ON : DB_WAIT_A;
                        wait_d  = dead;
                    end else if (wait_q <= 1) begin
                        state_d = DB_B_ON;
                    end else begin
                        wait_d = wait_q - 1'b1;
                    end
                end
                DB_B_ON: begin
                    if (mod_now) begin
                        state_d = no_gap ? DB_A_ON : DB_WAIT_A;
                        wait_d  = dead;
                    end
                end
                DB_WAIT_A: begin
                    if (!mod_now) begin
                        state_d = no_gap ? DB_B_ON : DB_WAIT_B;
                        wait_d  = dead;
                    end else if (wait_q <= 1) begin
                        state_d = DB_A_ON;
                    end else begin
                        wait_d = wait_q - 1'b1;
                    end
                end
                default: begin
                    state_d = DB_OFF;
                    wait_d  = '0;
                end
            endcase
        end
    end

    always_comb begin
        on_a = 1'b0;
        on_b = 1'b0;
        unique case (state_q)
            DB_A_ON: on_a = 1'b1;
            DB_B_ON: on_b = 1'b1;
            default: begin
                on_a = 1'b0;
                on_b = 1'b0;
            end
        endcase
    end

    AST_GAP_BEFORE_A: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on_a) && !no_gap) |-> !$past(on_b)); // R7

    AST_GAP_BEFORE_B: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on_b) && !no_gap) |-> !$past(on_a)); // R7

endmodule

// File: rtl/pwm_pin_steer.sv
module pwm_pin_steer
    import pwm_steer_pkg::*;
(
    input  logic             run,
    input  logic [1:0]       bridge_cfg,
    input  logic [1:0]       pol_sel,
    input  logic             mod_q,
    input  logic             on_a,
    input  logic             on_b,
    output logic [NPINS-1:0] pin_lvl,
    output logic [NPINS-1:0] pin_oe
);
    logic [NPINS-1:0] act;
    bridge_cfg_e      cfg;

    assign cfg = bridge_cfg_e'(bridge_cfg);

    always_comb begin
        act    = '0;
        pin_oe = '0;
        if (run) begin
            unique case (cfg)
                CFG_SINGLE: begin
                    pin_oe[PIN_A] = 1'b1;
                    act[PIN_A]    = mod_q;
                end
                CFG_HALF: begin
                    pin_oe[PIN_A] = 1'b1;
                    pin_oe[PIN_B] = 1'b1;
                    act[PIN_A]    = on_a;
                    act[PIN_B]    = on_b;
                end
                CFG_FWD: begin
                    pin_oe     = '1;
                    act[PIN_A] = 1'b1;
                    act[PIN_D] = mod_q;
                end
                CFG_REV: begin
                    pin_oe     = '1;
                    act[PIN_C] = 1'b1;
                    act[PIN_B] = mod_q;
                end
                default: begin
                    pin_oe = '0;
                    act    = '0;
                end
            endcase
        end
    end

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pol
        localparam int POL_BIT = (gi % 2 == 0) ? 1 : 0;
        assign pin_lvl[gi] = pin_oe[gi] & (act[gi] ^ pol_sel[POL_BIT]);
    end

endmodule

// File: rtl/pwm_steer_top.sv
module pwm_steer_top
    import pwm_steer_pkg::*;
#(
    parameter int TW   = 8,
    parameter int SUBW = 2,
    parameter int DBW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_on,
    input  logic [TW-1:0]   duty_hi,
    input  logic [SUBW-1:0] duty_lo,
    input  logic [TW-1:0]   period,
    input  logic [1:0]      bridge_cfg,
    input  logic [1:0]      pol_sel,
    input  logic [DBW-1:0]  dead_cnt,
    output logic [3:0]      pin_lvl,
    output logic [3:0]      pin_oe
);
    logic mod_now;
    logic mod_q;
    logic on_a;
    logic on_b;
    logic hb_act;

    assign hb_act = pwm_on && (bridge_cfg == CFG_HALF);

    pwm_timebase #(.TW(TW), .SUBW(SUBW)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pwm_on),
        .period  (period),
        .duty_hi (duty_hi),
        .duty_lo (duty_lo),
        .mod_now (mod_now),
        .mod_q   (mod_q)
    );

    pwm_deadband #(.DBW(DBW)) u_deadband (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (hb_act),
        .mod_now (mod_now),
        .dead    (dead_cnt),
        .on_a    (on_a),
        .on_b    (on_b)
    );

    pwm_pin_steer u_steer (
        .run        (pwm_on),
        .bridge_cfg (bridge_cfg),
        .pol_sel    (pol_sel),
        .mod_q      (mod_q),
        .on_a       (on_a),
        .on_b       (on_b),
        .pin_lvl    (pin_lvl),
        .pin_oe     (pin_oe)
    );

    AST_HB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_act && $past(hb_act) && dead_cnt == '0 && $past(dead_cnt) == '0)
        |-> (on_a == mod_q) && (on_b == !mod_q)); // R6

endmodule

// File: tb/pwm_steer_top_tb.sv
module pwm_steer_top_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_on = 1'b0;
    logic [7:0] duty_hi = '0;
    logic [1:0] duty_lo = '0;
    logic [7:0] period = '0;
    logic [1:0] bridge_cfg = '0;
    logic [1:0] pol_sel = '0;
    logic [5:0] dead_cnt = '0;
    logic [3:0] pin_lvl;
    logic [3:0] pin_oe;

    always #2.5 clk = ~clk;

    pwm_steer_top u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .duty_hi(duty_hi),
        .duty_lo(duty_lo), .period(period), .bridge_cfg(bridge_cfg),
        .pol_sel(pol_sel), .dead_cnt(dead_cnt), .pin_lvl(pin_lvl), .pin_oe(pin_oe)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    // behavioural reference state
    int m_phase = 0;
    int m_duty  = 0;
    bit m_wave  = 1'b0;
    int m_hold  = 0;

    always @(posedge clk) begin
        int wrap_at;
        bit now_wave;
        if (!rst_n) begin
            m_phase = 0; m_duty = 0; m_wave = 1'b0; m_hold = 0;
        end else begin
            wrap_at  = int'(period) * 4 + 3;
            now_wave = pwm_on && (m_phase < m_duty);
            if (pwm_on && bridge_cfg == 2'b10) begin
                if (m_hold > 0 && now_wave == m_wave) begin
                    if (m_hold < 100000) m_hold++;
                end else m_hold = 1;
            end else m_hold = 0;
            m_wave = now_wave;
            if (!pwm_on || m_phase == wrap_at) begin
                m_phase = 0;
                m_duty  = int'({duty_hi, duty_lo});
            end else m_phase = (m_phase + 1) % 1024;
        end
    end

    function automatic void predict(output logic [3:0] ep, output logic [3:0] ee);
        logic [3:0] act;
        bit settled;
        act = '0; ee = '0;
        if (pwm_on) begin
            case (bridge_cfg)
                2'b00: begin ee = 4'b0001; act[0] = m_wave; end
                2'b10: begin
                    ee = 4'b0011;
                    settled = (m_hold >= int'(dead_cnt) + 1);
                    act[0] = m_wave && settled;
                    act[1] = !m_wave && settled;
                end
                2'b01: begin ee = 4'b1111; act[0] = 1'b1; act[3] = m_wave; end
                default: begin ee = 4'b1111; act[2] = 1'b1; act[1] = m_wave; end
            endcase
        end
        for (int i = 0; i < 4; i++)
            ep[i] = ee[i] & (act[i] ^ ((i % 2 == 0) ? pol_sel[1] : pol_sel[0]));
    endfunction

    always @(negedge clk) begin
        logic [3:0] ep, ee;
        if (!finished) begin
            predict(ep, ee);
            n_cmp++;
            if (ep !== pin_lvl || ee !== pin_oe) begin
                n_bad++;
                $display("FAIL %s: pin_lvl=%b pin_oe=%b expected %b %b at %0t",
                         tag, pin_lvl, pin_oe, ep, ee, $time);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_duty(input int d);
        duty_hi = d[9:2];
        duty_lo = d[1:0];
    endtask

    // R3: count active cycles of pin A over one full period window
    task automatic count_window(input int span, input int want);
        int hits = 0;
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            if (pin_lvl[0]) hits++;
        end
        n_cmp++;
        if (hits != want) begin
            n_bad++;
            $display("FAIL R3: active count %0d expected %0d", hits, want);
        end
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        cycles(5);
        rst_n = 1'b1;
        cycles(4);

        tag = "R2";
        bridge_cfg = 2'b01; pol_sel = 2'b11; set_duty(30); period = 8'd9;
        cycles(10);

        tag = "R5"; bridge_cfg = 2'b00; pol_sel = 2'b00; set_duty(22);
        pwm_on = 1'b1;
        cycles(120);
        tag = "R3";
        count_window(40, 22);
        cycles(5);

        tag = "R11"; set_duty(0);
        cycles(90);
        count_window(40, 0);
        set_duty(1023);
        cycles(90);
        count_window(40, 40);

        tag = "R4"; set_duty(10);
        cycles(57);
        set_duty(31);
        cycles(13);
        set_duty(3);
        cycles(60);

        tag = "R6"; set_duty(17); dead_cnt = 6'd0; bridge_cfg = 2'b10;
        cycles(120);

        tag = "R7"; bridge_cfg = 2'b00;
        cycles(2);
        dead_cnt = 6'd3; bridge_cfg = 2'b10;
        cycles(150);
        bridge_cfg = 2'b00;
        cycles(1);
        dead_cnt = 6'd7; set_duty(5); bridge_cfg = 2'b10;
        cycles(150);

        tag = "R10"; pol_sel = 2'b01;
        cycles(60);
        pol_sel = 2'b10;
        cycles(60);

        tag = "R8"; bridge_cfg = 2'b01; pol_sel = 2'b00; set_duty(25);
        cycles(100);
        tag = "R10"; pol_sel = 2'b11;
        cycles(50);

        tag = "R9"; bridge_cfg = 2'b11; pol_sel = 2'b00;
        cycles(100);
        tag = "R10"; pol_sel = 2'b10;
        cycles(50);

        tag = "R2"; pwm_on = 1'b0;
        cycles(20);
        period = 8'd2; set_duty(6); bridge_cfg = 2'b10; dead_cnt = 6'd1;
        tag = "R7"; pwm_on = 1'b1;
        cycles(80);

        tag = "R1"; rst_n = 1'b0; pwm_on = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule